// File: doc/BRIEF.md
# Baud and Frame Configurator

This block turns a serial channel's configuration bytes into the settings a serializer needs. It holds four configuration bytes: a frame-control byte, a character-control byte, and the low and high bytes of a 16-bit time constant. From these it drives four outputs: whether parity is used, which parity sense is selected, whether two stop bits are used, and the character length.

A two-stage divider runs from a reference clock, nominally 2.4576 MHz, and makes a periodic baud tick. The first stage divides by the time constant plus two. The second stage divides by 1, 16, 32 or 64, as chosen in the frame-control byte. The tick period is therefore (time constant + 2) × prescale reference cycles.

A write to any of the four configuration addresses updates the decoded outputs at once. It also restarts the divider from the new settings, so the first tick after a reconfiguration comes a full period later and never partway through an old period. Writes to any other address are ignored. The serializer and the bus that carries the writes sit outside this block.

Top module: `baud_frame_cfg`

## Requirements
- R1: The frame-control byte is at address 4. Its bit 0 drives `parityEn`. Its bit 1 drives `parityEven` (1 = even, 0 = odd), whatever the value of bit 0.
- R2: `twoStop` is 1 when bits 3:2 of the frame-control byte are 11, and 0 for every other value of those bits.
- R3: The character-control byte is at address 5. Its bits 6:5 set `dataBits`: 00 gives 5, 01 gives 7, 10 gives 6 and 11 gives 8. All other bits of that byte are ignored.
- R4: The time constant is the byte at address 12 (low) joined with the byte at address 13 (high). The first divider stage has a period of time constant + 2 clock cycles.
- R5: Bits 7:6 of the frame-control byte select the second-stage factor: 00 gives 1, 01 gives 16, 10 gives 32 and 11 gives 64. Consecutive ticks are (time constant + 2) × factor cycles apart.
- R6: `baudTick` is high for exactly one clock cycle per period.
- R7: A write to address 4, 5, 12 or 13 on clock edge k updates the decoded outputs after edge k. It restarts the divider at edge k+1. The first tick is then high in the cycle after edge k+1+P, where P is the new period. This holds even when the value written equals the old one.
- R8: `baudTick` is low in the cycle after the restart edge, so no tick appears while a reload is pending.
- R9: A write to any other address leaves every output and the tick phase unchanged.
- R10: On reset, parity is off, odd parity and one stop bit are selected, the character length is 5, the time constant is 0 and the factor is 1. After reset is released, the first tick comes after edge 2 and the ticks repeat every 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the divider counts on every edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Write strobe for a configuration byte |
| cfgAddr | input | ADDR_W (4) | Register index of the write |
| cfgWrData | input | 8 | Byte to store |
| parityEn | output | 1 | Parity bit is generated and checked |
| parityEven | output | 1 | 1 = even parity, 0 = odd |
| twoStop | output | 1 | 1 = two stop bits, 0 = one |
| dataBits | output | 4 | Character length, 5 to 8 |
| baudTick | output | 1 | One-cycle pulse at the baud rate |

## Verification
The embedded properties check four things on every cycle:
- the tick is never wider than one cycle;
- no tick follows a restart edge;
- both divider counters stay within their loaded limits;
- every configuration write raises the reload strobe, while any other write leaves the outputs and the time constant untouched. The stop-bit and 7-bit length decodes are also checked against the byte written.

Only the bench's scenarios can show the exact tick spacing for each prescale and time constant. The same holds for the placement of the first tick after a write or after reset, the non-monotonic length encoding across all four codes, and a same-value rewrite moving the tick phase.

// File: rtl/baud_cfg_pkg.sv
package baud_cfg_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned TC_W   = 2 * BYTE_W;
  localparam int unsigned PRE_W  = 6;

  typedef enum logic [1:0] {
    PRE_DIV1  = 2'b00,
    PRE_DIV16 = 2'b01,
    PRE_DIV32 = 2'b10,
    PRE_DIV64 = 2'b11
  } prescale_e;

  // strobes and settings handed from control to datapath
  typedef struct packed {
    logic            reload;
    logic [TC_W-1:0] timeConst;
    prescale_e       prescaleSel;
  } divCtl_t;

  // terminal count of the second stage (factor minus one)
  function automatic logic [PRE_W-1:0] preLimitOf(prescale_e sel);
    case (sel)
      PRE_DIV1:  preLimitOf = PRE_W'(0);
      PRE_DIV16: preLimitOf = PRE_W'(15);
      PRE_DIV32: preLimitOf = PRE_W'(31);
      default:   preLimitOf = PRE_W'(63);
    endcase
  endfunction

endpackage

// File: rtl/baud_cfg_ctrl.sv
module baud_cfg_ctrl
  import baud_cfg_pkg::*;
#(
  parameter int unsigned         ADDR_W     = 4,
  parameter logic [ADDR_W-1:0]   FRAME_ADDR = 4,
  parameter logic [ADDR_W-1:0]   CHAR_ADDR  = 5,
  parameter logic [ADDR_W-1:0]   TCLO_ADDR  = 12,
  parameter logic [ADDR_W-1:0]   TCHI_ADDR  = 13,
  parameter logic [BYTE_W-1:0]   FRAME_RST  = 8'h04,
  parameter logic [BYTE_W-1:0]   CHAR_RST   = 8'h00,
  parameter logic [BYTE_W-1:0]   TCLO_RST   = 8'h00,
  parameter logic [BYTE_W-1:0]   TCHI_RST   = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  output divCtl_t           divCtl,
  output logic              parityEn,
  output logic              parityEven,
  output logic              twoStop,
  output logic [3:0]        dataBits
);

  localparam int unsigned NREG      = 4;
  localparam int unsigned IDX_FRAME = 0;
  localparam int unsigned IDX_CHAR  = 1;
  localparam int unsigned IDX_TCLO  = 2;
  localparam int unsigned IDX_TCHI  = 3;

  function automatic logic [ADDR_W-1:0] regAddr(int unsigned idx);
    case (idx)
      IDX_FRAME: regAddr = FRAME_ADDR;
      IDX_CHAR:  regAddr = CHAR_ADDR;
      IDX_TCLO:  regAddr = TCLO_ADDR;
      default:   regAddr = TCHI_ADDR;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] regRst(int unsigned idx);
    case (idx)
      IDX_FRAME: regRst = FRAME_RST;
      IDX_CHAR:  regRst = CHAR_RST;
      IDX_TCLO:  regRst = TCLO_RST;
      default:   regRst = TCHI_RST;
    endcase
  endfunction

  logic [BYTE_W-1:0] regQ [NREG];
  logic [NREG-1:0]   hit;
  logic              reloadPend;

  for (genvar gi = 0; gi < NREG; gi++) begin : g_cfgReg
    logic [BYTE_W-1:0] byteQ;
    assign hit[gi] = wrEn && (addr == regAddr(gi));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        byteQ <= regRst(gi);
      else if (hit[gi]) byteQ <= wrData;
    end
    assign regQ[gi] = byteQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reloadPend <= 1'b0;
    else       reloadPend <= |hit;
  end

  assign divCtl.reload      = reloadPend;
  assign divCtl.timeConst   = {regQ[IDX_TCHI], regQ[IDX_TCLO]};
  assign divCtl.prescaleSel = prescale_e'(regQ[IDX_FRAME][7:6]);

  always_comb begin
    parityEn   = regQ[IDX_FRAME][0];
    parityEven = regQ[IDX_FRAME][1];
    twoStop    = (regQ[IDX_FRAME][3:2] == 2'b11);
    case (regQ[IDX_CHAR][6:5])
      2'b00:   dataBits = 4'd5;
      2'b01:   dataBits = 4'd7;
      2'b10:   dataBits = 4'd6;
      default: dataBits = 4'd8;
    endcase
  end

  logic unusedCfgBits;
  assign unusedCfgBits = ^{regQ[IDX_FRAME][5:4], regQ[IDX_CHAR][7], regQ[IDX_CHAR][4:0]};

  function automatic logic isCfgAddr(logic [ADDR_W-1:0] a);
    isCfgAddr = (a == FRAME_ADDR) || (a == CHAR_ADDR) ||
                (a == TCLO_ADDR)  || (a == TCHI_ADDR);
  endfunction

  // R7
  cfg_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && isCfgAddr(addr)) |=> divCtl.reload);

  // R9
  foreign_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !isCfgAddr(addr)) |=>
      ($stable(dataBits) && $stable(parityEn) && $stable(parityEven) &&
       $stable(twoStop) && $stable(divCtl.timeConst) && !divCtl.reload));

  // R2
  stop_decode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == FRAME_ADDR) |=> (twoStop == ($past(wrData[3:2]) == 2'b11)));

  // R3
  len7_decode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == CHAR_ADDR && wrData[6:5] == 2'b01) |=> (dataBits == 4'd7));

endmodule

// File: rtl/baud_div_dp.sv
module baud_div_dp
  import baud_cfg_pkg::*;
#(
  parameter logic [TC_W-1:0] RST_TC  = '0,
  parameter prescale_e       RST_SEL = PRE_DIV1
) (
  input  logic    clk,
  input  logic    rstN,
  input  divCtl_t divCtl,
  output logic    baudTick
);

  localparam logic [TC_W:0]    RST_BASE = {1'b0, RST_TC} + (TC_W+1)'(1);
  localparam logic [PRE_W-1:0] RST_PRE  = preLimitOf(RST_SEL);

  logic [TC_W:0]    baseCnt, baseLimit;
  logic [PRE_W-1:0] preCnt, preLimitQ;
  logic             tickQ;
  logic [TC_W:0]    newBase;
  logic [PRE_W-1:0] newPre;

  assign newBase = {1'b0, divCtl.timeConst} + (TC_W+1)'(1);
  assign newPre  = preLimitOf(divCtl.prescaleSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseLimit <= RST_BASE;
      baseCnt   <= RST_BASE;
      preLimitQ <= RST_PRE;
      preCnt    <= RST_PRE;
      tickQ     <= 1'b0;
    end else if (divCtl.reload) begin
      baseLimit <= newBase;
      baseCnt   <= newBase;
      preLimitQ <= newPre;
      preCnt    <= newPre;
      tickQ     <= 1'b0;
    end else if (baseCnt == '0) begin
      baseCnt <= baseLimit;
      if (preCnt == '0) begin
        preCnt <= preLimitQ;
        tickQ  <= 1'b1;
      end else begin
        preCnt <= preCnt - PRE_W'(1);
        tickQ  <= 1'b0;
      end
    end else begin
      baseCnt <= baseCnt - (TC_W+1)'(1);
      tickQ   <= 1'b0;
    end
  end

  assign baudTick = tickQ;

  // R6
  tick_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    baudTick |=> !baudTick);

  // R8
  reload_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    divCtl.reload |=> !baudTick);

  // R4
  base_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    baseCnt <= baseLimit);

  // R5
  pre_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= preLimitQ);

endmodule

// File: rtl/baud_frame_cfg.sv
module baud_frame_cfg
  import baud_cfg_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 4,
  parameter logic [ADDR_W-1:0] FRAME_ADDR = 4,
  parameter logic [ADDR_W-1:0] CHAR_ADDR  = 5,
  parameter logic [ADDR_W-1:0] TCLO_ADDR  = 12,
  parameter logic [ADDR_W-1:0] TCHI_ADDR  = 13,
  parameter logic [7:0]        FRAME_RST  = 8'h04,
  parameter logic [7:0]        CHAR_RST   = 8'h00,
  parameter logic [7:0]        TCLO_RST   = 8'h00,
  parameter logic [7:0]        TCHI_RST   = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [7:0]        cfgWrData,
  output logic              parityEn,
  output logic              parityEven,
  output logic              twoStop,
  output logic [3:0]        dataBits,
  output logic              baudTick
);

  divCtl_t divCtl;

  baud_cfg_ctrl #(
    .ADDR_W(ADDR_W), .FRAME_ADDR(FRAME_ADDR), .CHAR_ADDR(CHAR_ADDR),
    .TCLO_ADDR(TCLO_ADDR), .TCHI_ADDR(TCHI_ADDR), .FRAME_RST(FRAME_RST),
    .CHAR_RST(CHAR_RST), .TCLO_RST(TCLO_RST), .TCHI_RST(TCHI_RST)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(cfgWrEn), .addr(cfgAddr), .wrData(cfgWrData),
    .divCtl(divCtl), .parityEn(parityEn), .parityEven(parityEven),
    .twoStop(twoStop), .dataBits(dataBits)
  );

  baud_div_dp #(
    .RST_TC({TCHI_RST, TCLO_RST}),
    .RST_SEL(prescale_e'(FRAME_RST[7:6]))
  ) i_dp (
    .clk(clk), .rstN(rstN), .divCtl(divCtl), .baudTick(baudTick)
  );

endmodule

// File: tb/test_baud_frame_cfg.sv
`timescale 1ns/1ps
module test_baud_frame_cfg;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [3:0] cfgAddr = '0;
  logic [7:0] cfgWrData = '0;
  logic       parityEn, parityEven, twoStop, baudTick;
  logic [3:0] dataBits;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  baud_frame_cfg i_baud_frame_cfg (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .parityEn(parityEn), .parityEven(parityEven),
    .twoStop(twoStop), .dataBits(dataBits), .baudTick(baudTick)
  );

  typedef struct packed {
    logic [7:0] frame;
    logic [7:0] chr;
    logic [7:0] tcLo;
    logic [7:0] tcHi;
    logic       pe;
    logic       ev;
    logic       ts;
    logic [3:0] bits;
    int         period;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 4'd5, 2},
    '{8'h01, 8'h20, 8'h05, 8'h00, 1'b1, 1'b0, 1'b0, 4'd7, 7},
    '{8'h0F, 8'h40, 8'h01, 8'h00, 1'b1, 1'b1, 1'b1, 4'd6, 3},
    '{8'h48, 8'h60, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 4'd8, 32},
    '{8'h84, 8'h00, 8'h03, 8'h00, 1'b0, 1'b0, 1'b0, 4'd5, 160},
    '{8'hCD, 8'h20, 8'h02, 8'h00, 1'b1, 1'b0, 1'b1, 4'd7, 256},
    '{8'h00, 8'h9F, 8'h10, 8'h01, 1'b0, 1'b0, 1'b0, 4'd5, 274},
    '{8'h06, 8'h7F, 8'hFF, 8'h00, 1'b0, 1'b1, 1'b0, 4'd8, 257}
  };

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a falling edge; the write is captured on the next rising edge
  task automatic wr(logic [3:0] a, logic [7:0] d);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // relative to the last write edge (j=0): first tick at 1+P, second at 1+2P
  task automatic measure(int period, string req);
    int first = -1;
    int second = -1;
    int n = 0;
    for (int j = 1; j <= 1 + 2 * period; j++) begin
      @(negedge clk);
      if (baudTick) begin
        n++;
        if (n == 1) first = j;
        else if (n == 2) second = j;
      end
    end
    chk(first == 1 + period, {req, " R7 first tick"}, first, 1 + period);
    chk(second == 1 + 2 * period, {req, " R5 spacing"}, second, 1 + 2 * period);
    chk(n == 2, {req, " R6 single-cycle ticks"}, n, 2);
  endtask

  initial begin : watchdog
    #(200000 * 8);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int tk[4];
    int bad;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(parityEn == 1'b0, "R10 parityEn", parityEn, 0);
    chk(twoStop == 1'b0, "R10 twoStop", twoStop, 0);
    chk(dataBits == 4'd5, "R10 dataBits", dataBits, 5);
    chk(baudTick == 1'b0, "R10 tick in reset", baudTick, 0);
    rstN = 1'b1;
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      tk[j] = baudTick;
    end
    chk(tk[0] == 0 && tk[1] == 1 && tk[2] == 0 && tk[3] == 1, "R10 tick pattern",
        tk[0] * 1000 + tk[1] * 100 + tk[2] * 10 + tk[3], 101);

    // table of configurations
    for (int v = 0; v < NVEC; v++) begin
      wr(4'd4, VECS[v].frame);
      wr(4'd5, VECS[v].chr);
      wr(4'd12, VECS[v].tcLo);
      wr(4'd13, VECS[v].tcHi);
      chk(parityEn == VECS[v].pe, "R1 parityEn", parityEn, VECS[v].pe);
      chk(parityEven == VECS[v].ev, "R1 parityEven", parityEven, VECS[v].ev);
      chk(twoStop == VECS[v].ts, "R2 twoStop", twoStop, VECS[v].ts);
      chk(dataBits == VECS[v].bits, "R3 dataBits", dataBits, VECS[v].bits);
      measure(VECS[v].period, "R4");
    end

    // R7 R8: same-value rewrite mid-period restarts the phase
    wr(4'd4, 8'h00); wr(4'd5, 8'h00); wr(4'd13, 8'h00); wr(4'd12, 8'h05);
    repeat (3) @(negedge clk);
    wr(4'd12, 8'h05);
    measure(7, "R8 restart");

    // R9: writes elsewhere leave outputs and tick phase alone
    wr(4'd4, 8'h01); wr(4'd5, 8'h20); wr(4'd13, 8'h00); wr(4'd12, 8'h05);
    bad = 0;
    for (int j = 1; j <= 15; j++) begin
      if (j == 3) begin cfgWrEn = 1'b1; cfgAddr = 4'd6; cfgWrData = 8'hFF; end
      if (j == 5) begin cfgWrEn = 1'b1; cfgAddr = 4'd0; cfgWrData = 8'hCC; end
      @(negedge clk);
      cfgWrEn = 1'b0;
      if (baudTick != (j == 8 || j == 15)) bad++;
    end
    chk(bad == 0, "R9 tick phase after foreign writes", bad, 0);
    chk(dataBits == 4'd7 && parityEn == 1'b1 && twoStop == 1'b0,
        "R9 outputs after foreign writes", dataBits, 7);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule